// File: doc/BRIEF.md
# Interleaved Forward State-Metric Recursion

This block runs the forward (alpha) recursion of a soft-output trellis decoder for a four-state binary trellis. The trellis belongs to a rate-1/2 recursive systematic code with feedback polynomial 1+D+D² and parity polynomial 1+D². A decoding block is cut into `M` sub-blocks, and all of them share one add-compare-select array. The array takes the sub-blocks in strict rotation, one trellis section per clock. The recursion loop therefore contains `M` registers, and the add/compare and select/correct/rescale halves sit in separate pipeline stages. Each sub-block sees exactly the recursion it would see on its own, non-pipelined datapath.

A pulse on `start` begins a block. In that cycle and in each of the cycles that follow, the caller presents the four branch metrics of the next section in the schedule. Sub-blocks other than the first begin with a warm-up run over the `L` sections that precede them, starting from equal metrics. The first sub-block starts from its known initial state. Each result comes out with the index of its sub-block and a flag that separates warm-up results from final ones.

The sequencer has three states:
- `PH_IDLE` waits for `start`.
- `PH_WARM` covers M·L cycles of warm-up.
- `PH_MAIN` covers M·S cycles of final sections.

Its transitions are:
- IDLE→WARM on `start` when M>1, or IDLE→MAIN on `start` when M=1.
- WARM→MAIN after the last warm-up cycle.
- MAIN→IDLE after the last main cycle.

Top module: `bip_fwd_recursion`

## Requirements
- R1: After reset, `out_valid` is low, and it stays low until a section has been accepted after a `start` pulse.
- R2: States are numbered s = 2·s1 + s0. Input bit u from state s gives feedback bit a = u^s1^s0, parity p = a^s0 and next state 2·a + s1. The branch uses `gamma` slice 2·u+p, that is bits [(2u+p)·BW +: BW]. Each new metric combines the two branches that enter its state, each branch being old metric + branch metric.
- R3: The two candidates x and y are combined as max(x,y) + T[min(|x−y|,7)], where T = {3,2,2,2,1,1,1,1} for indices 0 to 7.
- R4: Each combined value is first clipped to 2^W−1. If the clipped state-0 value then exceeds 2^(W−1), that value is subtracted from every state, and results below zero become 0. Otherwise no subtraction happens. State 0 of `out_metric` occupies bits [W−1:0], and state i occupies bits [i·W +: W].
- R5: The k-th cycle of a block, counting from 0 at the `start` cycle, carries sub-block k mod M. The first M·L cycles are warm-up and the next M·S cycles are main.
- R6: Sub-block 0 enters its first main section with the metrics {START_BIAS,0,0,0}. Every other sub-block enters its first warm-up section with all metrics zero. It then continues from its own previous result, with no reload between warm-up and main.
- R7: The result of a section appears exactly min(M,2) cycles after that section's input cycle. It carries `out_valid`=1, `out_tag` equal to the sub-block, and `out_final`=1 only for main sections. Warm-up cycles of sub-block 0 produce no output, and a warm-up result is never directly followed by... is never preceded in the previous cycle by a final result.
- R8: A `start` pulse while a block is in progress has no effect. Once the block ends, `out_valid` stays low until a new `start`.
- R9: The stream of results is bit-exact with M independent recursions that follow R2–R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a block; this cycle carries the first section |
| gamma | input | 4·BW | Branch metrics of the current section, slice 2·u+p |
| out_valid | output | 1 | A result is present |
| out_tag | output | TW | Sub-block index of the result |
| out_final | output | 1 | 1 for a main-section result, 0 for warm-up |
| out_metric | output | 4·W | Updated state metrics, state i at [i·W +: W] |

## Verification
Clipping at the ceiling and state-0 rescaling can both act on the same update. They interact, because the subtraction uses a state-0 value that has already been clipped. A block of very large branch metrics on a rotating codeword drives some states into the ceiling while state 0 crosses half range. Every such result is compared in full against an independent per-sub-block model. A second coincidence is also provoked: a `start` pulse lands mid-block in the same cycle as a section. It must be ignored, and the tag sequence and metrics confirm this.

// File: rtl/bip_pkg.sv
package bip_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WARM = 2'd1,
        PH_MAIN = 2'd2
    } phase_e;

    localparam int CORR_IDX_MAX = 7;

    // correction term, scale 1/4, indexed by the clipped metric gap
    function automatic logic [2:0] corr_lookup(input logic [2:0] idx);
        logic [2:0] r;
        unique case (idx)
            3'd0:             r = 3'd3;
            3'd1, 3'd2, 3'd3: r = 3'd2;
            default:          r = 3'd1;
        endcase
        return r;
    endfunction

    // predecessor of next state ns along branch br (br is the oldest state bit)
    function automatic logic [1:0] pred_state(input logic [1:0] ns, input logic br);
        return {ns[0], br};
    endfunction

    // codeword {u,p} on that branch
    function automatic logic [1:0] pred_code(input logic [1:0] ns, input logic br);
        logic u;
        logic p;
        u = ns[1] ^ ns[0] ^ br;
        p = ns[1] ^ br;
        return {u, p};
    endfunction

endpackage

// File: rtl/bip_ctrl.sv
module bip_ctrl
    import bip_pkg::*;
#(
    parameter int M = 2,
    parameter int L = 4,
    parameter int S = 8,
    localparam int TW = (M > 1) ? $clog2(M) : 1,
    localparam int CW = $clog2(((L > S) ? L : S) + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          sec_act,
    output logic [TW-1:0] sec_slot,
    output logic          sec_warm,
    output logic          sec_first
);

    phase_e        state_q, state_d, cur_ph;
    logic [TW-1:0] slot_q, slot_d;
    logic [CW-1:0] step_q, step_d;
    logic          slot_last, step_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            slot_q  <= '0;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            step_q  <= step_d;
        end
    end

    always_comb begin
        cur_ph = state_q;
        if (state_q == PH_IDLE && start) begin
            if (M > 1) cur_ph = PH_WARM;
            else       cur_ph = PH_MAIN;
        end
    end

    always_comb begin
        slot_last = (slot_q == TW'(M - 1));
        if (cur_ph == PH_WARM) step_last = (step_q == CW'(L - 1));
        else                   step_last = (step_q == CW'(S - 1));
    end

    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        step_d  = step_q;
        unique case (cur_ph)
            PH_IDLE: begin
                state_d = PH_IDLE;
            end
            PH_WARM, PH_MAIN: begin
                state_d = cur_ph;
                if (slot_last) begin
                    slot_d = '0;
                    if (step_last) begin
                        step_d = '0;
                        if (cur_ph == PH_WARM) state_d = PH_MAIN;
                        else                   state_d = PH_IDLE;
                    end else begin
                        step_d = step_q + CW'(1);
                    end
                end else begin
                    slot_d = slot_q + TW'(1);
                end
            end
            default: begin
                state_d = PH_IDLE;
                slot_d  = '0;
                step_d  = '0;
            end
        endcase
    end

    always_comb begin
        sec_act   = (cur_ph != PH_IDLE);
        sec_warm  = (cur_ph == PH_WARM);
        sec_first = (step_q == '0);
        sec_slot  = slot_q;
    end

endmodule

// File: rtl/bip_add_array.sv
module bip_add_array
    import bip_pkg::*;
#(
    parameter int W  = 10,
    parameter int BW = 8,
    localparam int SW = W + 2
) (
    input  logic [4*W-1:0]  metric_in,
    input  logic [4*BW-1:0] gamma_in,
    output logic [8*SW-1:0] cand
);

    for (genvar ns = 0; ns < 4; ns++) begin : g_ns
        for (genvar br = 0; br < 2; br++) begin : g_br
            localparam int PS = int'(pred_state(2'(ns), 1'(br)));
            localparam int PC = int'(pred_code(2'(ns), 1'(br)));
            assign cand[(ns*2+br)*SW +: SW] =
                SW'(metric_in[PS*W +: W]) + SW'(gamma_in[PC*BW +: BW]);
        end
    end

endmodule

// File: rtl/bip_select_array.sv
module bip_select_array
    import bip_pkg::*;
#(
    parameter int W = 10,
    localparam int SW   = W + 2,
    localparam int MAXV = (2 ** W) - 1,
    localparam int HALF = 2 ** (W - 1)
) (
    input  logic [8*SW-1:0] cand,
    output logic [4*W-1:0]  metric_out
);

    logic [4*W-1:0] clip_vec;

    for (genvar ns = 0; ns < 4; ns++) begin : g_ns
        logic [SW-1:0] ca, cb, hi, gap, tot;
        logic [2:0]    idx;
        logic [W-1:0]  clip;

        assign ca = cand[(ns*2)*SW +: SW];
        assign cb = cand[(ns*2+1)*SW +: SW];

        always_comb begin
            if (ca >= cb) begin
                hi  = ca;
                gap = ca - cb;
            end else begin
                hi  = cb;
                gap = cb - ca;
            end
            idx  = (gap > SW'(CORR_IDX_MAX)) ? 3'(CORR_IDX_MAX) : gap[2:0];
            tot  = hi + SW'(corr_lookup(idx));
            clip = (tot > SW'(MAXV)) ? W'(MAXV) : tot[W-1:0];
        end

        assign clip_vec[ns*W +: W] = clip;
    end

    logic [W-1:0] ref0, v;
    logic         shift;

    always_comb begin
        ref0       = clip_vec[W-1:0];
        shift      = (ref0 > W'(HALF));
        metric_out = '0;
        v          = '0;
        for (int i = 0; i < 4; i++) begin
            v = clip_vec[i*W +: W];
            if (!shift)        metric_out[i*W +: W] = v;
            else if (v > ref0) metric_out[i*W +: W] = v - ref0;
            else               metric_out[i*W +: W] = '0;
        end
    end

endmodule

// File: rtl/bip_delay_line.sv
module bip_delay_line #(
    parameter int D  = 0,
    parameter int WD = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [WD-1:0] din,
    output logic [WD-1:0] dout
);

    if (D == 0) begin : g_wire
        assign dout = din;
    end else begin : g_regs
        logic [WD-1:0] pipe [D];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < D; i++) pipe[i] <= '0;
            end else begin
                pipe[0] <= din;
                for (int i = 1; i < D; i++) pipe[i] <= pipe[i-1];
            end
        end
        assign dout = pipe[D-1];
    end

endmodule

// File: rtl/bip_fwd_recursion.sv
module bip_fwd_recursion
    import bip_pkg::*;
#(
    parameter int M          = 2,
    parameter int L          = 4,
    parameter int S          = 8,
    parameter int W          = 10,
    parameter int BW         = 8,
    parameter int START_BIAS = 64,
    localparam int TW = (M > 1) ? $clog2(M) : 1,
    localparam int SW = W + 2,
    localparam int P  = (M > 1) ? 2 : 1,
    localparam int DL = M - P
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [4*BW-1:0] gamma,
    output logic            out_valid,
    output logic [TW-1:0]   out_tag,
    output logic            out_final,
    output logic [4*W-1:0]  out_metric
);

    logic          sec_act, sec_warm, sec_first;
    logic [TW-1:0] sec_slot;
    logic          fresh_known, fresh_zero, live;
    logic [4*W-1:0]  fb, src, nxt;
    logic [8*SW-1:0] cand, sel_in;
    logic            sb_live, sb_fin;
    logic [TW-1:0]   sb_tag;
    logic            valid_q, fin_q;
    logic [TW-1:0]   tag_q;
    logic [4*W-1:0]  metric_q;

    bip_ctrl #(.M(M), .L(L), .S(S)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .sec_act  (sec_act),
        .sec_slot (sec_slot),
        .sec_warm (sec_warm),
        .sec_first(sec_first)
    );

    always_comb begin
        fresh_known = sec_act && !sec_warm && sec_first && (sec_slot == '0);
        fresh_zero  = sec_act && sec_warm && sec_first;
        live        = sec_act && !(sec_warm && (sec_slot == '0));
        src         = fb;
        if (fresh_known) begin
            src        = '0;
            src[W-1:0] = W'(START_BIAS);
        end else if (fresh_zero) begin
            src = '0;
        end
    end

    bip_add_array #(.W(W), .BW(BW)) u_add (
        .metric_in(src),
        .gamma_in (gamma),
        .cand     (cand)
    );

    if (P == 2) begin : g_two
        logic [8*SW-1:0] s1_cand;
        logic            s1_live, s1_fin;
        logic [TW-1:0]   s1_tag;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_cand <= '0;
                s1_live <= 1'b0;
                s1_fin  <= 1'b0;
                s1_tag  <= '0;
            end else begin
                s1_cand <= cand;
                s1_live <= live;
                s1_fin  <= !sec_warm;
                s1_tag  <= sec_slot;
            end
        end
        assign sel_in  = s1_cand;
        assign sb_live = s1_live;
        assign sb_fin  = s1_fin;
        assign sb_tag  = s1_tag;
    end else begin : g_one
        assign sel_in  = cand;
        assign sb_live = live;
        assign sb_fin  = !sec_warm;
        assign sb_tag  = sec_slot;
    end

    bip_select_array #(.W(W)) u_sel (
        .cand      (sel_in),
        .metric_out(nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            fin_q    <= 1'b0;
            tag_q    <= '0;
            metric_q <= '0;
        end else begin
            valid_q  <= sb_live;
            fin_q    <= sb_fin;
            tag_q    <= sb_tag;
            metric_q <= nxt;
        end
    end

    bip_delay_line #(.D(DL), .WD(4*W)) u_loop (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (metric_q),
        .dout (fb)
    );

    assign out_valid  = valid_q;
    assign out_tag    = tag_q;
    assign out_final  = fin_q;
    assign out_metric = metric_q;

endmodule

// File: rtl/bip_fwd_recursion_chk.sv
module bip_fwd_recursion_chk #(
    parameter int M = 2,
    parameter int W = 10,
    localparam int TW   = (M > 1) ? $clog2(M) : 1,
    localparam int HALF = 2 ** (W - 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          out_valid,
    input logic [TW-1:0] out_tag,
    input logic          out_final,
    input logic [W-1:0]  metric0
);

    logic [TW-1:0] seen_tag, want_tag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_tag <= '0;
        else        seen_tag <= out_tag;
    end

    always_comb want_tag = (seen_tag == TW'(M - 1)) ? '0 : seen_tag + TW'(1);

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);

    // R5
    tag_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(out_valid) |-> out_tag == want_tag);

    // R4
    rescale_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> metric0 <= W'(HALF));

    // R7
    warm_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_final |-> out_tag != '0);

    // R7
    phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_final && $past(out_valid) |-> !$past(out_final));

endmodule

bind bip_fwd_recursion bip_fwd_recursion_chk #(.M(M), .W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_valid(out_valid),
    .out_tag  (out_tag),
    .out_final(out_final),
    .metric0  (out_metric[W-1:0])
);

// File: tb/bip_fwd_recursion_tb.sv
module bip_fwd_recursion_tb;

    localparam int M = 2, L = 4, S = 8, W = 10, BW = 8, BIAS = 64, TW = 1, LAT = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [4*BW-1:0] gamma = '0;
    logic            out_valid;
    logic [TW-1:0]   out_tag;
    logic            out_final;
    logic [4*W-1:0]  out_metric;

    always #10 clk = ~clk;

    bip_fwd_recursion #(.M(M), .L(L), .S(S), .W(W), .BW(BW), .START_BIAS(BIAS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .gamma(gamma),
        .out_valid(out_valid), .out_tag(out_tag), .out_final(out_final),
        .out_metric(out_metric)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0, n_errors = 0;
    bit done = 1'b0;
    int q_tag[$], q_fin[$], q_cyc[$], q_m[$];
    int alpha[M][4];
    int lut[8] = '{3, 2, 2, 2, 1, 1, 1, 1};

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // R2/R3/R4 reference step for one sub-block, enumerated forward over (state, input)
    function automatic void model_step(input int slot, input int g[4]);
        int c[4][2];
        int k[4];
        int nv[4];
        int r0;
        for (int i = 0; i < 4; i++) k[i] = 0;
        for (int s = 0; s < 4; s++) begin
            for (int u = 0; u < 2; u++) begin
                int s1, s0, a, p, ns;
                s1 = s >> 1; s0 = s & 1;
                a = u ^ s1 ^ s0; p = a ^ s0; ns = 2 * a + s1;
                c[ns][k[ns]] = alpha[slot][s] + g[2 * u + p];
                k[ns]++;
            end
        end
        for (int n = 0; n < 4; n++) begin
            int mx, d;
            mx = (c[n][0] > c[n][1]) ? c[n][0] : c[n][1];
            d  = (c[n][0] > c[n][1]) ? c[n][0] - c[n][1] : c[n][1] - c[n][0];
            if (d > 7) d = 7;
            nv[n] = mx + lut[d];
            if (nv[n] > 1023) nv[n] = 1023;
        end
        r0 = nv[0];
        for (int n = 0; n < 4; n++) begin
            if (r0 > 512) alpha[slot][n] = (nv[n] > r0) ? nv[n] - r0 : 0;
            else          alpha[slot][n] = nv[n];
        end
    endfunction

    // R5/R6 schedule; `again` is a cycle index that repeats start mid-block (R8)
    task automatic run_block(input int mode, input int again);
        int total;
        total = M * (L + S);
        for (int c = 0; c < total; c++) begin
            int g[4];
            int slot, step;
            bit warm;
            @(negedge clk);
            slot = c % M;
            warm = (c < M * L);
            step = warm ? c / M : (c - M * L) / M;
            for (int k = 0; k < 4; k++) begin
                case (mode)
                    0: g[k] = int'($urandom_range(0, 40));
                    1: g[k] = (k == (c % 4)) ? 255 : int'($urandom_range(0, 8));
                    2: g[k] = 0;
                    default: g[k] = int'($urandom_range(0, 255));
                endcase
                gamma[k*BW +: BW] = BW'(g[k]);
            end
            start = (c == 0) || (c == again);
            if (!(warm && slot == 0)) begin
                if (warm && step == 0)
                    for (int n = 0; n < 4; n++) alpha[slot][n] = 0;
                if (!warm && step == 0 && slot == 0) begin
                    for (int n = 0; n < 4; n++) alpha[slot][n] = 0;
                    alpha[slot][0] = BIAS;
                end
                model_step(slot, g);
                q_tag.push_back(slot);
                q_fin.push_back(warm ? 0 : 1);
                q_cyc.push_back(cyc);
                for (int n = 0; n < 4; n++) q_m.push_back(alpha[slot][n]);
            end
        end
        @(negedge clk);
        start = 1'b0;
        gamma = '0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (q_tag.size() == 0) begin
                check("R7", "unexpected result", 1, 0);
            end else begin
                int et, ef, ec;
                et = q_tag.pop_front();
                ef = q_fin.pop_front();
                ec = q_cyc.pop_front();
                check("R5", "sub-block tag", int'(out_tag), et);
                check("R7", "final flag", int'(out_final), ef);
                check("R7", "latency", cyc - ec, LAT);
                for (int i = 0; i < 4; i++)
                    check("R9", $sformatf("metric of state %0d", i),
                          int'(out_metric[i*W +: W]), q_m.pop_front());
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", "valid after reset without start", int'(out_valid), 0);

        run_block(0, -1);          // R2 R3 R6: moderate metrics
        repeat (6) @(negedge clk);
        check("R8", "valid after block end", int'(out_valid), 0);

        run_block(1, -1);          // R4: ceiling and rescale together
        run_block(2, 9);           // R3 R8: zero metrics, stray start mid-block
        run_block(3, -1);          // R9: full-range metrics
        repeat (6) @(negedge clk);
        check("R8", "valid after last block", int'(out_valid), 0);
        check("R7", "results still pending", q_tag.size(), 0);
        finish_run();
    end

endmodule